// File: doc/BRIEF.md
# Pulse period and width meter

The block measures a single digital pulse train. The input pin is brought into the clock domain by a short flop chain. The block then watches both of its edges. One edge is chosen as the active edge and the other becomes the opposite edge. A prescaled up-counter restarts on every active edge.

On each active edge the counter value is latched as the period. On each opposite edge the counter value is latched as the time spent at the active level. Software reads both values directly, with no subtraction. Each capture raises a status flag, and either flag can raise an interrupt. A wrap of the counter before the next active edge raises an overflow flag, which tells software that the next period value is not valid.

Control uses a single-cycle write strobe with an address. Reads are combinational from the same address. The register map is:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit0 run, bit1 period-interrupt enable, bit2 width-interrupt enable |
| 1 | prescaler | division value P |
| 2 | mode | bit0: 0 makes the rising edge active, 1 makes the falling edge active |
| 3 | status | bit0 period flag, bit1 width flag, bit2 overflow flag |
| 4 | period capture | read only |
| 5 | width capture | read only |
| 6 | live counter | read only |

Top module: `pulse_meter`

## Requirements
- R1: After reset, every register (control, prescaler, mode, status, period, width, counter) reads zero and `irq_o` is low.
- R2: With prescaler value P at address 1, the counter advances once every P+1 clocks while running. A capture taken D clocks after the previous active edge therefore holds floor((D-1)/(P+1)).
- R3: On an active edge while running, the counter value goes into the period register at address 4. The counter and prescaler restart from zero, and status bit0 (period flag) sets.
- R4: On an opposite edge while running, the counter value goes into the width register at address 5, and status bit1 (width flag) sets. This holds for a pulse one clock long, which reads 0.
- R5: Mode bit0 = 0 makes the rising edge active and the falling edge opposite. Mode bit0 = 1 swaps the two edges.
- R6: `irq_o` is high when status bit0 and control bit1 are both set, or when status bit1 and control bit2 are both set. The overflow flag never drives `irq_o`.
- R7: A write to status at address 3 clears every flag whose written bit is 0 and keeps every flag whose written bit is 1. A capture in the same clock as the clearing write leaves its flag set.
- R8: Writing control with bit0 = 1 while stopped clears all flags, loads the interrupt enables from bits 1 and 2, and starts the counter. The same write while already running has no effect.
- R9: Writing control with bit0 = 0 stops the counter and clears all flags and both interrupt enables.
- R10: While stopped, input edges capture nothing and set no flag, and the counter holds its value.
- R11: Any write to the prescaler (address 1) or the mode register (address 2) stops the block, clears the flags and interrupt enables, and zeroes both captures and the counter.
- R12: A prescaler tick at counter value all-ones wraps the counter to zero and sets status bit2 (overflow flag). If an active edge falls in the same clock, the edge restart wins and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous pulse input |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for writes and reads |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt: enabled capture flags |

## Verification
The bench builds the block with a 10-bit counter and an 8-bit prescaler. With these widths a counter wrap occurs after about a thousand clocks. This puts both the overflow flag and the case where an edge and the wrap land in the same clock within reach of a short run. Small prescaler values from 0 to 3 are mixed with random pulse shapes and both polarities. This exercises the floor-division rounding of every capture. A write to the status register is timed to land in the same clock as a capture, to check that the capture wins.

// File: rtl/pulse_meter_pkg.sv
package pulse_meter_pkg;

   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL   = 3'd0,
      REG_PSC    = 3'd1,
      REG_MODE   = 3'd2,
      REG_STAT   = 3'd3,
      REG_PERIOD = 3'd4,
      REG_WIDTH  = 3'd5,
      REG_COUNT  = 3'd6
   } reg_addr_e;

   // control register bit positions
   localparam int CTRL_RUN = 0;
   localparam int CTRL_PIE = 1;
   localparam int CTRL_WIE = 2;

   // capture channel indices
   localparam int CH_PERIOD = 0;
   localparam int CH_WIDTH  = 1;
   localparam int NUM_CH    = 2;

   typedef struct packed {
      logic ovf;   // bit2
      logic wid;   // bit1
      logic per;   // bit0
   } flags_t;

endpackage

// File: rtl/pulse_meter_edge.sv
module pulse_meter_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic inv_i,
   output logic act_o,
   output logic opp_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pulse_meter_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;
   logic              prev_q;
   logic              rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], pin_i};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign rise  = stg_q[STAGES-1] & ~prev_q;
   assign fall  = ~stg_q[STAGES-1] & prev_q;
   assign act_o = inv_i ? fall : rise;
   assign opp_o = inv_i ? rise : fall;

endmodule

// File: rtl/pulse_meter_timebase.sv
module pulse_meter_timebase #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clear_i,
   input  logic             restart_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [PSC_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick = (pre_q == psc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (clear_i) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (run_i) begin
         if (restart_i) begin
            pre_q <= '0;
            cnt_q <= '0;
         end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   // a restart takes the place of the wrap, so it never reports overflow
   assign wrap_o  = run_i && !clear_i && !restart_i && tick && (cnt_q == CNT_TOP);
   assign count_o = cnt_q;

endmodule

// File: rtl/pulse_meter_capture.sv
module pulse_meter_capture #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             strobe_i,
   input  logic [CNT_W-1:0] value_i,
   output logic [CNT_W-1:0] cap_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_o <= '0;
      else if (clear_i)  cap_o <= '0;
      else if (strobe_i) cap_o <= value_i;
   end

endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
   import pulse_meter_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pin_i,
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  irq_o
);

   if (DATA_W < CNT_W || DATA_W < PSC_W || DATA_W < 3) begin : g_bad_width
      $error("pulse_meter: DATA_W must cover counter, prescaler and control fields");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("pulse_meter: CNT_W must be at least 2");
   end

   // register decode
   logic wr_ctrl, wr_psc, wr_mode, wr_stat, reconfig;
   assign wr_ctrl  = wr_en_i && (addr_i == REG_CTRL);
   assign wr_psc   = wr_en_i && (addr_i == REG_PSC);
   assign wr_mode  = wr_en_i && (addr_i == REG_MODE);
   assign wr_stat  = wr_en_i && (addr_i == REG_STAT);
   assign reconfig = wr_psc | wr_mode;

   logic             run_q;
   logic [1:0]       ie_q;
   logic [PSC_W-1:0] psc_q;
   logic             inv_q;
   flags_t           flags_q;

   // input edges
   logic act_edge, opp_edge, act_hit, opp_hit;

   pulse_meter_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i),
      .inv_i (inv_q),
      .act_o (act_edge),
      .opp_o (opp_edge)
   );

   assign act_hit = run_q && act_edge;
   assign opp_hit = run_q && opp_edge;

   // timebase
   logic [CNT_W-1:0] cnt;
   logic             wrap;

   pulse_meter_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .clear_i   (reconfig),
      .restart_i (act_hit),
      .psc_i     (psc_q),
      .count_o   (cnt),
      .wrap_o    (wrap)
   );

   // capture channels: channel 0 on active edge, channel 1 on opposite edge
   logic [NUM_CH-1:0] cap_stb;
   logic [CNT_W-1:0]  cap_val [NUM_CH];

   assign cap_stb[CH_PERIOD] = act_hit;
   assign cap_stb[CH_WIDTH]  = opp_hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
      pulse_meter_capture #(.CNT_W(CNT_W)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear_i  (reconfig),
         .strobe_i (cap_stb[c]),
         .value_i  (cnt),
         .cap_o    (cap_val[c])
      );
   end

   // flag update: software clear first, hardware set on top of it
   logic [2:0] flags_kept, flags_next;
   assign flags_kept = wr_stat ? (flags_q & wdata_i[2:0]) : flags_q;
   assign flags_next = flags_kept | {wrap, opp_hit, act_hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ie_q    <= '0;
         psc_q   <= '0;
         inv_q   <= 1'b0;
         flags_q <= '0;
      end else if (reconfig) begin
         run_q   <= 1'b0;
         ie_q    <= '0;
         flags_q <= '0;
         if (wr_psc)  psc_q <= wdata_i[PSC_W-1:0];
         if (wr_mode) inv_q <= wdata_i[0];
      end else if (wr_ctrl && !wdata_i[CTRL_RUN]) begin
         run_q   <= 1'b0;
         ie_q    <= '0;
         flags_q <= '0;
      end else if (wr_ctrl && !run_q) begin
         run_q   <= 1'b1;
         ie_q    <= wdata_i[CTRL_WIE:CTRL_PIE];
         flags_q <= '0;
      end else begin
         flags_q <= flags_next;
      end
   end

   assign irq_o = (flags_q.per & ie_q[0]) | (flags_q.wid & ie_q[1]);

   // read port
   always_comb begin
      rdata_o = '0;
      case (reg_addr_e'(addr_i))
         REG_CTRL:   rdata_o = DATA_W'({ie_q, run_q});
         REG_PSC:    rdata_o = DATA_W'(psc_q);
         REG_MODE:   rdata_o = DATA_W'(inv_q);
         REG_STAT:   rdata_o = DATA_W'(flags_q);
         REG_PERIOD: rdata_o = DATA_W'(cap_val[CH_PERIOD]);
         REG_WIDTH:  rdata_o = DATA_W'(cap_val[CH_WIDTH]);
         REG_COUNT:  rdata_o = DATA_W'(cnt);
         default:    rdata_o = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/pulse_meter_chk.sv
module pulse_meter_chk
   import pulse_meter_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en_i,
   input logic [REG_ADDR_W-1:0] addr_i,
   input logic                  run,
   input logic                  act_edge,
   input logic                  opp_edge,
   input logic [1:0]            ie,
   input logic [2:0]            flags,
   input logic [CNT_W-1:0]      count,
   input logic [CNT_W-1:0]      period,
   input logic [CNT_W-1:0]      width,
   input logic                  irq
);

   logic reconf, ctl_wr, quiet;
   assign reconf = wr_en_i && (addr_i == REG_PSC || addr_i == REG_MODE);
   assign ctl_wr = wr_en_i && (addr_i == REG_CTRL);
   assign quiet  = !reconf && !ctl_wr;

   // R3: active edge restarts the counter and raises the period flag
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run && act_edge && quiet |=> (count == '0) && flags[0]);

   // R4: opposite edge raises the width flag
   p_width_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run && opp_edge && quiet |=> flags[1]);

   // R6: no interrupt without an enable
   p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie != 2'b00));

   // R9: a stopped block never interrupts
   p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !irq);

   // R10: counter holds while stopped
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !reconf |=> $stable(count));

   // R11: reconfiguration zeroes captures and counter and stops
   p_reconfig_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |=> (count == '0) && (period == '0) && (width == '0) && !run);

   // R12: overflow is only flagged out of an all-ones counter
   p_ovf_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[2]) |-> ($past(count) == {CNT_W{1'b1}}));

endmodule

bind pulse_meter pulse_meter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en_i  (wr_en_i),
   .addr_i   (addr_i),
   .run      (run_q),
   .act_edge (act_edge),
   .opp_edge (opp_edge),
   .ie       (ie_q),
   .flags    (flags_q),
   .count    (cnt),
   .period   (cap_val[0]),
   .width    (cap_val[1]),
   .irq      (irq_o)
);

// File: tb/pulse_meter_test.sv
module pulse_meter_test;
   import pulse_meter_pkg::*;

   localparam int CNT_W  = 10;
   localparam int PSC_W  = 8;
   localparam int DATA_W = 16;
   localparam int CMOD   = 1 << CNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pin = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        addr = 3'd0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq;

   int n_chk = 0;
   int n_bad = 0;
   bit cur_inv = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pulse_meter #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin),
      .wr_en_i (wr_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   function automatic int exp_cnt(int d, int p);
      return ((d - 1) / (p + 1)) % CMOD;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, int d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = DATA_W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic drive(bit active, int n);
      pin = active ? ~cur_inv : cur_inv;
      wait_cyc(n);
   endtask

   task automatic measure(int p, bit inv, int h1, int l1, int h2, int l2, string tag);
      int v;
      cur_inv = inv;
      pin = inv;
      wait_cyc(4);
      wr(REG_PSC, p);
      wr(REG_MODE, int'(inv));
      wr(REG_CTRL, 7);
      drive(1, h1); drive(0, l1); drive(1, h2); drive(0, l2);
      drive(1, 6);
      rd(REG_PERIOD, v); check({tag, " period"}, v, exp_cnt(h2 + l2, p));
      rd(REG_WIDTH, v);  check({tag, " width"},  v, exp_cnt(h2, p));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int v, p0, c0;
      void'($urandom(32'h5eed_0042));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1 reset state
      rd(REG_CTRL, v);   check("R1 ctrl", v, 0);
      rd(REG_STAT, v);   check("R1 status", v, 0);
      rd(REG_PERIOD, v); check("R1 period", v, 0);
      rd(REG_WIDTH, v);  check("R1 width", v, 0);
      rd(REG_COUNT, v);  check("R1 count", v, 0);
      check("R1 irq", int'(irq), 0);

      // R3 R4 basic, R2 prescaled, R5 falling-edge active, R4 one-clock pulse
      measure(0, 1'b0, 5, 7, 5, 7, "R3 R4 p0");
      measure(3, 1'b0, 9, 11, 9, 11, "R2 p3");
      measure(1, 1'b1, 6, 3, 6, 3, "R5 inv");
      measure(2, 1'b0, 4, 4, 1, 9, "R4 single");
      rd(REG_STAT, v); check("R3 R4 flags", v, 3);
      check("R6 irq both enabled", int'(irq), 1);

      // R9 stop clears flags and enables
      wr(REG_CTRL, 0);
      rd(REG_STAT, v); check("R9 status", v, 0);
      rd(REG_CTRL, v); check("R9 ctrl", v, 0);
      check("R9 irq", int'(irq), 0);

      // R8 start with period interrupt only
      wr(REG_CTRL, 3);
      rd(REG_CTRL, v); check("R8 ctrl", v, 3);
      drive(0, 5); drive(1, 5); drive(0, 5);
      rd(REG_STAT, v); check("R6 flags", v, 3);
      check("R6 irq period", int'(irq), 1);
      wr(REG_STAT, 6);
      rd(REG_STAT, v); check("R7 partial clear", v, 2);
      check("R6 width flag masked", int'(irq), 0);
      wr(REG_CTRL, 7);
      rd(REG_CTRL, v); check("R8 run write ignored ctrl", v, 3);
      rd(REG_STAT, v); check("R8 run write ignored status", v, 2);

      // R7 capture in the same clock as a clearing write
      pin = ~cur_inv;
      @(negedge clk); @(negedge clk);
      wr_en = 1'b1; addr = REG_STAT; wdata = '0;
      @(negedge clk);
      wr_en = 1'b0;
      rd(REG_STAT, v); check("R7 capture wins", v, 1);
      check("R6 irq after capture", int'(irq), 1);

      // R10 stopped ignores edges, counter holds
      wr(REG_CTRL, 0);
      rd(REG_PERIOD, p0);
      rd(REG_COUNT, c0);
      drive(0, 4); drive(1, 4); drive(0, 4); drive(1, 4);
      rd(REG_PERIOD, v); check("R10 period held", v, p0);
      rd(REG_COUNT, v);  check("R10 count held", v, c0);
      rd(REG_STAT, v);   check("R10 no flags", v, 0);

      // R11 reconfiguration
      wr(REG_CTRL, 1);
      drive(0, 6); drive(1, 6); drive(0, 8);
      wr(REG_PSC, 2);
      rd(REG_PERIOD, v); check("R11 period", v, 0);
      rd(REG_WIDTH, v);  check("R11 width", v, 0);
      rd(REG_COUNT, v);  check("R11 count", v, 0);
      rd(REG_CTRL, v);   check("R11 ctrl", v, 0);
      rd(REG_PSC, v);    check("R11 psc", v, 2);

      // R12 wrap: edge on the wrap clock wins, one clock later flags overflow
      cur_inv = 1'b0; pin = 1'b0; wait_cyc(4);
      wr(REG_PSC, 0); wr(REG_MODE, 0); wr(REG_CTRL, 7);
      drive(1, 4); drive(0, 4); drive(1, 10); drive(0, 1014);
      drive(1, 6);
      rd(REG_PERIOD, v); check("R12 edge at top", v, CMOD - 1);
      rd(REG_STAT, v);   check("R12 no overflow", (v >> 2) & 1, 0);
      wait_cyc(4);
      drive(0, 1015);
      drive(1, 6);
      rd(REG_PERIOD, v); check("R12 wrapped period", v, 0);
      rd(REG_STAT, v);   check("R12 overflow flag", (v >> 2) & 1, 1);
      check("R6 overflow no irq share", int'(irq), 1);

      // random shapes, prescalers and polarities (R2 R3 R4 R5)
      for (int i = 0; i < 24; i++) begin
         int p, h1, l1, h2, l2;
         bit inv;
         p   = int'($urandom_range(0, 3));
         inv = 1'($urandom_range(0, 1));
         h1  = int'($urandom_range(1, 50));
         l1  = int'($urandom_range(1, 50));
         h2  = int'($urandom_range(1, 50));
         l2  = int'($urandom_range(1, 50));
         measure(p, inv, h1, l1, h2, l2, "R2 R5 random");
         rd(REG_STAT, v); check("R3 R4 random flags", v, 3);
         check("R6 random irq", int'(irq), 1);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule